// File: doc/BRIEF.md
# Flash Command, Status and Interrupt Register Set

This block is the control face of a buffered NAND-style flash controller as seen from a 16-bit register bus. Software writes a command code into the command register. The block checks whether a command may be accepted right now and sorts the code into a class: load, program, erase, plain, suspend, reset or unknown. Work for the flash core goes out as a one-cycle opcode pulse. When the core answers with a done flag, which may carry a failure flag, the block sets the completion bits in the interrupt register and the error bits in the status register. The flash array, the data buffers and ECC are not part of this block.

The interrupt register has a global pending bit (bit 15). While that bit is set, new commands are refused. Software acknowledges by writing a mask, which is ANDed into the register. Once the global bit is clear, every error flag is wiped at the same time. The interrupt pin is the global bit, inverted or not according to a polarity bit in the first configuration register. A ready pin follows a second bit of that register.

Top module: `flash_cmd_irq`

## Requirements
- R1: Register addresses are: 0 command, 1 config A, 2 config B, 3 status, 4 interrupt. Any other address reads 0. A cold reset (`rst_n` low) leaves command 0x0000, config A 0x40C0, config B 0x0000, status 0x0000, interrupt 0x8080, and `ready_out` high.
- R2: A command write is ignored while interrupt bit 15 is set, and also while an earlier command still waits for the core. In both cases the command register keeps its value and no `op_valid` pulse appears.
- R3: An accepted core command raises `op_valid` for exactly one cycle, on the cycle after the write. `op_code` carries the code, and the command register reads back the code. The core codes are load (0x00, 0x13), program (0x80, 0x1A, 0x1B), erase (0x94, 0x95, 0x30) and plain (0x23, 0x27, 0x2A, 0x2C, 0x65, 0x71).
- R4: When the core reports done, the interrupt bits set are: load gives 15 and 7; program gives 15 and 6; erase gives 15 and 5; plain gives 15 only.
- R5: A done that carries a failure also sets status bit 10 (command error), in the same cycle as the done bits. It also sets the bit for the class: 13 for load, 12 for program, 11 for erase, none for plain.
- R6: An unknown code sets status bit 10 and interrupt bit 15 on the next cycle, with no `op_valid` pulse. Suspend (0xB0) is stored in the command register but changes no flag and sends no pulse.
- R7: A write to the interrupt register ANDs the data into it. If bit 15 is clear afterwards, status bits 13..10 are cleared. If bit 15 is still set, those bits keep their value.
- R8: `irq_out` equals interrupt bit 15 XOR the inverse of config A bit 6.
- R9: On a write to config A, `ready_out` takes data bit 7 and holds it until the next config A write or reset.
- R10: Config A reads back masked with 0xFFE0. Config B reads back exactly as written.
- R11: Codes 0xF0 and 0xF3, and a one-cycle `warm_req`, perform a warm reset. It restores the R1 values, except that the interrupt register becomes 0x8010. It drops any command in flight, so a later done from the core leaves the flags unchanged.
- R12: A read strobe returns its data on `reg_rdata` one clock later. The data reflects the registers as they were before that edge, and `reg_rdata` holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous cold reset, active low |
| warm_req | input | 1 | Synchronous warm reset request |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after the strobe |
| op_valid | output | 1 | One-cycle command pulse to the flash core |
| op_code | output | CODE_W | Command code for the core |
| op_done | input | 1 | Core completion flag |
| op_fail | input | 1 | Core failure flag, qualified by op_done |
| irq_out | output | 1 | Interrupt line with programmable polarity |
| ready_out | output | 1 | Ready line |

## Verification
A wrong busy or pending state shows up at the ports within one cycle. Either a command that should be refused raises `op_valid`, or a command that should go out is dropped, and both pulses are compared on every clock. If a wrong class is latched for the command in flight, it stays hidden until the core reports done. On the next cycle it appears as the wrong completion or error bits, and because `irq_out` follows bit 15 combinationally, as the wrong pin level. Flag corruption from a faulty acknowledge or warm reset is seen on the next interrupt or status read, one cycle after the read strobe.

// File: rtl/fci_pkg.sv
package fci_pkg;

  localparam int DATA_W   = 16;
  localparam int NUM_REGS = 5;

  // register addresses
  localparam int A_CMD  = 0;
  localparam int A_CFGA = 1;
  localparam int A_CFGB = 2;
  localparam int A_STAT = 3;
  localparam int A_INT  = 4;

  // reset values
  localparam logic [DATA_W-1:0] CFGA_RST      = 16'h40C0;
  localparam logic [DATA_W-1:0] INT_COLD_RST  = 16'h8080;
  localparam logic [DATA_W-1:0] INT_WARM_RST  = 16'h8010;
  localparam logic [DATA_W-1:0] CFGA_RD_MASK  = 16'hFFE0;

  // flag bit positions
  localparam int B_GLOBAL = 15;
  localparam int B_LOADED = 7;
  localparam int B_PROGD  = 6;
  localparam int B_ERASED = 5;
  localparam int B_ECMD   = 10;
  localparam int B_EERASE = 11;
  localparam int B_EPROG  = 12;
  localparam int B_ELOAD  = 13;
  localparam int B_POL    = 6;
  localparam int B_RDY    = 7;

  localparam logic [DATA_W-1:0] ERR_ALL =
    (DATA_W'(1) << B_ECMD) | (DATA_W'(1) << B_EERASE) |
    (DATA_W'(1) << B_EPROG) | (DATA_W'(1) << B_ELOAD);

  typedef enum logic [2:0] {
    K_LOAD, K_PROG, K_ERASE, K_PLAIN, K_HOLD, K_RESET, K_BAD
  } op_kind_e;

  function automatic op_kind_e kind_of(input logic [DATA_W-1:0] code);
    op_kind_e k;
    case (code)
      16'h0000, 16'h0013:                   k = K_LOAD;
      16'h0080, 16'h001A, 16'h001B:         k = K_PROG;
      16'h0094, 16'h0095, 16'h0030:         k = K_ERASE;
      16'h0023, 16'h0027, 16'h002A,
      16'h002C, 16'h0065, 16'h0071:         k = K_PLAIN;
      16'h00B0:                             k = K_HOLD;
      16'h00F0, 16'h00F3:                   k = K_RESET;
      default:                              k = K_BAD;
    endcase
    return k;
  endfunction

  function automatic logic goes_to_core(input op_kind_e k);
    return (k == K_LOAD) || (k == K_PROG) || (k == K_ERASE) || (k == K_PLAIN);
  endfunction

  function automatic logic [DATA_W-1:0] done_mask(input op_kind_e k);
    logic [DATA_W-1:0] m;
    m = '0;
    if (goes_to_core(k)) m[B_GLOBAL] = 1'b1;
    case (k)
      K_LOAD:  m[B_LOADED] = 1'b1;
      K_PROG:  m[B_PROGD]  = 1'b1;
      K_ERASE: m[B_ERASED] = 1'b1;
      default: ;
    endcase
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] fail_mask(input op_kind_e k);
    logic [DATA_W-1:0] m;
    m = '0;
    if (goes_to_core(k)) m[B_ECMD] = 1'b1;
    case (k)
      K_LOAD:  m[B_ELOAD]  = 1'b1;
      K_PROG:  m[B_EPROG]  = 1'b1;
      K_ERASE: m[B_EERASE] = 1'b1;
      default: ;
    endcase
    return m;
  endfunction

  // pin level: pending XOR inverted polarity bit
  function automatic logic irq_level(input logic pending, input logic pol);
    return pending ^ ~pol;
  endfunction

endpackage

// File: rtl/fci_cmd_gate.sv
module fci_cmd_gate
  import fci_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              int_pend,
  input  logic              op_done,
  input  logic              op_fail,
  output logic [DATA_W-1:0] cmd_q,
  output logic              op_valid,
  output logic [CODE_W-1:0] op_code,
  output logic              cmd_accept,
  output logic              reset_hit,
  output logic              bad_hit,
  output logic              op_finish,
  output logic [DATA_W-1:0] set_int,
  output logic [DATA_W-1:0] set_err
);

  logic     busy_q;
  op_kind_e kind_q;
  op_kind_e kind_in;

  always_comb begin
    kind_in    = kind_of(cmd_wdata);
    cmd_accept = cmd_wr && !int_pend && !busy_q;
    reset_hit  = cmd_accept && (kind_in == K_RESET);
    bad_hit    = cmd_accept && (kind_in == K_BAD);
    op_finish  = op_done && busy_q;
    set_int    = '0;
    set_err    = '0;
    if (op_finish) begin
      set_int = done_mask(kind_q);
      if (op_fail) set_err = fail_mask(kind_q);
    end else if (bad_hit) begin
      set_int[B_GLOBAL] = 1'b1;
      set_err[B_ECMD]   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      busy_q   <= 1'b0;
      op_valid <= 1'b0;
      kind_q   <= K_HOLD;
    end else if (soft_rst) begin
      cmd_q    <= '0;
      busy_q   <= 1'b0;
      op_valid <= 1'b0;
      kind_q   <= K_HOLD;
    end else begin
      op_valid <= 1'b0;
      if (op_finish) busy_q <= 1'b0;
      if (cmd_accept) begin
        cmd_q <= cmd_wdata;
        if (goes_to_core(kind_in)) begin
          busy_q   <= 1'b1;
          op_valid <= 1'b1;
          kind_q   <= kind_in;
        end
      end
    end
  end

  assign op_code = cmd_q[CODE_W-1:0];

endmodule

// File: rtl/fci_flag_regs.sv
module fci_flag_regs
  import fci_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              int_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] set_int,
  input  logic [DATA_W-1:0] set_err,
  output logic [DATA_W-1:0] int_q,
  output logic [DATA_W-1:0] stat_q
);

  logic [DATA_W-1:0] int_acked;
  logic [DATA_W-1:0] stat_kept;
  logic              ack_clears;

  always_comb begin
    int_acked  = int_wr ? (int_q & wdata) : int_q;
    ack_clears = int_wr && !int_acked[B_GLOBAL];
    stat_kept  = ack_clears ? (stat_q & ~ERR_ALL) : stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= INT_COLD_RST;
      stat_q <= '0;
    end else if (soft_rst) begin
      int_q  <= INT_WARM_RST;
      stat_q <= '0;
    end else begin
      int_q  <= int_acked | set_int;
      stat_q <= stat_kept | set_err;
    end
  end

endmodule

// File: rtl/fci_cfg_regs.sv
module fci_cfg_regs
  import fci_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cfga_wr,
  input  logic              cfgb_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg_a_q,
  output logic [DATA_W-1:0] cfg_b_q,
  output logic              ready_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_a_q <= CFGA_RST;
      cfg_b_q <= '0;
      ready_q <= 1'b1;
    end else if (soft_rst) begin
      cfg_a_q <= CFGA_RST;
      cfg_b_q <= '0;
      ready_q <= 1'b1;
    end else begin
      if (cfga_wr) begin
        cfg_a_q <= wdata;
        ready_q <= wdata[B_RDY];
      end
      if (cfgb_wr) cfg_b_q <= wdata;
    end
  end

endmodule

// File: rtl/flash_cmd_irq.sv
module flash_cmd_irq
  import fci_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_req,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              op_valid,
  output logic [CODE_W-1:0] op_code,
  input  logic              op_done,
  input  logic              op_fail,
  output logic              irq_out,
  output logic              ready_out
);

  logic [NUM_REGS-1:0] wr_sel;
  logic                cmd_wr, cfga_wr, cfgb_wr, int_wr;
  logic                soft_rst;
  logic                cmd_accept, reset_hit, bad_hit, op_finish;
  logic [DATA_W-1:0]   cmd_q, int_q, stat_q, cfg_a_q, cfg_b_q;
  logic [DATA_W-1:0]   set_int, set_err;
  logic [DATA_W-1:0]   rd_mux;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wsel
    assign wr_sel[i] = reg_wr && (reg_addr == ADDR_W'(i));
  end

  assign cmd_wr   = wr_sel[A_CMD];
  assign cfga_wr  = wr_sel[A_CFGA];
  assign cfgb_wr  = wr_sel[A_CFGB];
  assign int_wr   = wr_sel[A_INT];
  assign soft_rst = warm_req || reset_hit;

  fci_cmd_gate #(.CODE_W(CODE_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cmd_wr(cmd_wr), .cmd_wdata(reg_wdata), .int_pend(int_q[B_GLOBAL]),
    .op_done(op_done), .op_fail(op_fail),
    .cmd_q(cmd_q), .op_valid(op_valid), .op_code(op_code),
    .cmd_accept(cmd_accept), .reset_hit(reset_hit), .bad_hit(bad_hit),
    .op_finish(op_finish), .set_int(set_int), .set_err(set_err)
  );

  fci_flag_regs u_flags (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .int_wr(int_wr), .wdata(reg_wdata),
    .set_int(set_int), .set_err(set_err),
    .int_q(int_q), .stat_q(stat_q)
  );

  fci_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cfga_wr(cfga_wr), .cfgb_wr(cfgb_wr), .wdata(reg_wdata),
    .cfg_a_q(cfg_a_q), .cfg_b_q(cfg_b_q), .ready_q(ready_out)
  );

  always_comb begin
    case (reg_addr)
      ADDR_W'(A_CMD):  rd_mux = cmd_q;
      ADDR_W'(A_CFGA): rd_mux = cfg_a_q & CFGA_RD_MASK;
      ADDR_W'(A_CFGB): rd_mux = cfg_b_q;
      ADDR_W'(A_STAT): rd_mux = stat_q;
      ADDR_W'(A_INT):  rd_mux = int_q;
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign irq_out = irq_level(int_q[B_GLOBAL], cfg_a_q[B_POL]);

endmodule

// File: rtl/fci_checker.sv
module fci_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        cmd_wr,
  input logic        int_wr,
  input logic        cfga_wr,
  input logic [15:0] reg_wdata,
  input logic [15:0] cmd_q,
  input logic [15:0] int_q,
  input logic [15:0] stat_q,
  input logic        op_valid,
  input logic        op_finish,
  input logic        op_fail,
  input logic        bad_hit,
  input logic        ready_out
);

  AST_BLOCKED_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && int_q[15] && !soft_rst) |=> (cmd_q == $past(cmd_q)) && !op_valid); // R2

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid); // R3

  AST_FAIL_SETS_CMDERR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_finish && op_fail && !soft_rst) |=> stat_q[10] && int_q[15]); // R5

  AST_UNKNOWN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_hit && !soft_rst) |=> int_q[15] && stat_q[10] && !op_valid); // R6

  AST_ACK_CLEARS_ERRORS: assert property (@(posedge clk) disable iff (!rst_n)
    (int_wr && !reg_wdata[15] && !op_finish && !bad_hit && !soft_rst)
      |=> (stat_q[13:10] == 4'b0000)); // R7

  AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfga_wr && !soft_rst) |=> (ready_out == $past(reg_wdata[7]))); // R9

endmodule

bind flash_cmd_irq fci_checker u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
  .cmd_wr(cmd_wr), .int_wr(int_wr), .cfga_wr(cfga_wr),
  .reg_wdata(reg_wdata), .cmd_q(cmd_q), .int_q(int_q), .stat_q(stat_q),
  .op_valid(op_valid), .op_finish(op_finish), .op_fail(op_fail),
  .bad_hit(bad_hit), .ready_out(ready_out)
);

// File: tb/flash_cmd_irq_bench.sv
module flash_cmd_irq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm_req = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        op_valid;
  logic [7:0]  op_code;
  logic        op_done = 1'b0;
  logic        op_fail = 1'b0;
  logic        irq_out;
  logic        ready_out;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  flash_cmd_irq u_flash_cmd_irq (
    .clk(clk), .rst_n(rst_n), .warm_req(warm_req),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .op_valid(op_valid), .op_code(op_code),
    .op_done(op_done), .op_fail(op_fail),
    .irq_out(irq_out), .ready_out(ready_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model: class as an integer (0 none, 1 load, 2 prog, 3 erase, 4 plain, 5 hold, 6 reset, 7 bad)
  function automatic int cls(input logic [15:0] c);
    if (c == 16'h0000 || c == 16'h0013) return 1;
    if (c == 16'h0080 || c == 16'h001A || c == 16'h001B) return 2;
    if (c == 16'h0094 || c == 16'h0095 || c == 16'h0030) return 3;
    if (c == 16'h0023 || c == 16'h0027 || c == 16'h002A || c == 16'h002C ||
        c == 16'h0065 || c == 16'h0071) return 4;
    if (c == 16'h00B0) return 5;
    if (c == 16'h00F0 || c == 16'h00F3) return 6;
    return 7;
  endfunction

  logic [15:0] m_cmd, m_cfga, m_cfgb, m_stat, m_int, m_rdata;
  logic        m_rdy, m_opv;
  int          m_busy_cls;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = 0; m_cfga = 16'h40C0; m_cfgb = 0; m_stat = 0; m_int = 16'h8080;
      m_rdata = 0; m_rdy = 1; m_opv = 0; m_busy_cls = 0;
    end else begin
      logic go, warm, nv;
      int   k;
      if (reg_rd) begin
        case (reg_addr)
          3'd0: m_rdata = m_cmd;
          3'd1: m_rdata = {m_cfga[15:5], 5'b0};
          3'd2: m_rdata = m_cfgb;
          3'd3: m_rdata = m_stat;
          3'd4: m_rdata = m_int;
          default: m_rdata = 0;
        endcase
      end
      go   = reg_wr && reg_addr == 3'd0 && !m_int[15] && m_busy_cls == 0;
      k    = go ? cls(reg_wdata) : 0;
      warm = warm_req || k == 6;
      nv   = 0;
      if (warm) begin
        m_cmd = 0; m_cfga = 16'h40C0; m_cfgb = 0; m_stat = 0; m_int = 16'h8010;
        m_rdy = 1; m_busy_cls = 0;
      end else begin
        if (reg_wr && reg_addr == 3'd4) begin
          m_int = m_int & reg_wdata;
          if (!m_int[15]) m_stat[13:10] = 4'b0;
        end
        if (op_done && m_busy_cls != 0) begin
          m_int[15] = 1;
          if (m_busy_cls == 1) m_int[7] = 1;
          if (m_busy_cls == 2) m_int[6] = 1;
          if (m_busy_cls == 3) m_int[5] = 1;
          if (op_fail) begin
            m_stat[10] = 1;
            if (m_busy_cls == 1) m_stat[13] = 1;
            if (m_busy_cls == 2) m_stat[12] = 1;
            if (m_busy_cls == 3) m_stat[11] = 1;
          end
          m_busy_cls = 0;
        end
        if (go) begin
          m_cmd = reg_wdata;
          if (k == 7) begin m_int[15] = 1; m_stat[10] = 1; end
          if (k >= 1 && k <= 4) begin m_busy_cls = k; nv = 1; end
        end
        if (reg_wr && reg_addr == 3'd1) begin m_cfga = reg_wdata; m_rdy = reg_wdata[7]; end
        if (reg_wr && reg_addr == 3'd2) m_cfgb = reg_wdata;
      end
      m_opv = nv;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 irq_out", {15'b0, irq_out}, {15'b0, m_int[15] == m_cfga[6]});
      chk("R9 ready_out", {15'b0, ready_out}, {15'b0, m_rdy});
      chk("R3 op_valid", {15'b0, op_valid}, {15'b0, m_opv});
      if (m_opv) chk("R3 op_code", {8'b0, op_code}, {8'b0, m_cmd[7:0]});
      chk("R12 reg_rdata", reg_rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic finish_op(input logic f);
    op_done = 1; op_fail = f;
    @(negedge clk);
    op_done = 0; op_fail = 0;
  endtask

  task automatic run_op(input logic [15:0] code, input logic f,
                        input logic [15:0] exp_int, input logic [15:0] exp_stat, input string tag);
    wr(3'd0, code);
    chk({tag, " pulse"}, {15'b0, op_valid}, 16'd1);
    @(negedge clk);
    finish_op(f);
    rd(3'd4, exp_int, {tag, " int"});
    rd(3'd3, exp_stat, {tag, " status"});
    wr(3'd4, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 cold reset state
    rd(3'd0, 16'h0000, "R1 cmd");
    rd(3'd1, 16'h40C0, "R1 cfgA");
    rd(3'd2, 16'h0000, "R1 cfgB");
    rd(3'd3, 16'h0000, "R1 status");
    rd(3'd4, 16'h8080, "R1 int");
    rd(3'd6, 16'h0000, "R1 unmapped");
    chk("R1 ready", {15'b0, ready_out}, 16'd1);
    chk("R8 irq after cold", {15'b0, irq_out}, 16'd1);
    // R2 blocked while pending
    wr(3'd0, 16'h0080);
    chk("R2 no pulse", {15'b0, op_valid}, 16'd0);
    rd(3'd0, 16'h0000, "R2 cmd kept");
    // R7 acknowledge
    wr(3'd4, 16'h0000);
    rd(3'd4, 16'h0000, "R7 int cleared");
    chk("R8 irq low", {15'b0, irq_out}, 16'd0);
    // R3/R4 load success
    run_op(16'h0000, 0, 16'h8080, 16'h0000, "R4 load");
    // R2 busy blocks, R5 program fail
    wr(3'd0, 16'h001A);
    chk("R3 pulse prog", {15'b0, op_valid}, 16'd1);
    chk("R3 code prog", {8'b0, op_code}, 16'h001A);
    wr(3'd0, 16'h0094);
    chk("R2 busy no pulse", {15'b0, op_valid}, 16'd0);
    rd(3'd0, 16'h001A, "R2 cmd kept busy");
    finish_op(1);
    rd(3'd4, 16'h8040, "R5 prog int");
    rd(3'd3, 16'h1400, "R5 prog status");
    // R7 keep errors while bit 15 survives
    wr(3'd4, 16'h8000);
    rd(3'd4, 16'h8000, "R7 and");
    rd(3'd3, 16'h1400, "R7 errors kept");
    wr(3'd4, 16'h7FFF);
    rd(3'd3, 16'h0000, "R7 errors cleared");
    // more classes
    run_op(16'h0095, 1, 16'h8020, 16'h0C00, "R5 erase fail");
    run_op(16'h0030, 0, 16'h8020, 16'h0000, "R4 resume");
    run_op(16'h0023, 0, 16'h8000, 16'h0000, "R4 plain");
    run_op(16'h0071, 1, 16'h8000, 16'h0400, "R5 plain fail");
    run_op(16'h0013, 1, 16'h8080, 16'h2400, "R5 load fail");
    run_op(16'h001B, 0, 16'h8040, 16'h0000, "R4 copy prog");
    // R6 unknown and suspend
    wr(3'd0, 16'h0055);
    chk("R6 no pulse bad", {15'b0, op_valid}, 16'd0);
    rd(3'd4, 16'h8000, "R6 int bad");
    rd(3'd3, 16'h0400, "R6 status bad");
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h00B0);
    chk("R6 no pulse suspend", {15'b0, op_valid}, 16'd0);
    rd(3'd4, 16'h0000, "R6 suspend int");
    rd(3'd3, 16'h0000, "R6 suspend status");
    rd(3'd0, 16'h00B0, "R6 suspend stored");
    // R9/R10/R8 config
    wr(3'd1, 16'h123F);
    chk("R9 ready low", {15'b0, ready_out}, 16'd0);
    chk("R8 inverted idle", {15'b0, irq_out}, 16'd1);
    rd(3'd1, 16'h1220, "R10 mask");
    wr(3'd1, 16'h0080);
    chk("R9 ready high", {15'b0, ready_out}, 16'd1);
    wr(3'd2, 16'hBEEF);
    rd(3'd2, 16'hBEEF, "R10 cfgB");
    // R11 warm reset by command
    wr(3'd0, 16'h00F3);
    rd(3'd4, 16'h8010, "R11 int");
    rd(3'd1, 16'h40C0, "R11 cfgA");
    rd(3'd2, 16'h0000, "R11 cfgB");
    rd(3'd0, 16'h0000, "R11 cmd");
    // R11 warm_req drops op in flight
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h0080);
    warm_req = 1;
    @(negedge clk);
    warm_req = 0;
    finish_op(1);
    rd(3'd4, 16'h8010, "R11 late done int");
    rd(3'd3, 16'h0000, "R11 late done status");
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h00F0);
    rd(3'd4, 16'h8010, "R11 F0");
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule